// File: doc/BRIEF.md
# Single-Wire Byte Master Controller

This block is the master side of a half-duplex serial link that runs over one open-drain wire. Software stages one byte in a transmit register. It sets a direction bit and a start bit in the control register, and the block then runs one byte on the wire.

- **Transmit.** The block shifts the byte out least significant bit first. Each bit is one fixed-length slot that opens with a low pulse. A short pulse means 1 and a long pulse means 0. The wire is released for the rest of the slot.
- **Receive.** For each bit, the block waits for the slave to pull the wire low. It samples the wire a fixed number of cycles after that falling edge. The first bit it captures becomes the least significant bit of the receive register.

When the byte ends, the block records the outcome in a status register and raises one combined interrupt if the global enable allows it. The outcome is transmit done, receive done, or timed out. Software builds multi-byte exchanges by repeating single-byte transfers.

The wire is modelled as an input that samples the bus and an output enable that pulls the bus low when it is high. The bus input passes through a two-stage synchronizer before any decision uses it.

Top module: `swire_master`

## Requirements
- R1: After reset, `line_oe` is 0 and `irq` is 0. The status register (address 3) reads 0 and the control register (address 2) reads 0.
- R2: A transmit sends 8 bit slots of `SLOT_CYC` cycles each, least significant bit first. Each slot opens with `line_oe` high for `LOW1_CYC` cycles when the bit is 1, or for `LOW0_CYC` cycles when the bit is 0. `line_oe` is low for the rest of the slot and never high outside a transfer.
- R3: When a transmit completes, status bit 0 (transmit done) is set, status bit 2 (time-out) is clear, and control bit 1 (go) reads 0.
- R4: In a receive, each bit is the synchronized line level `SAMPLE_CYC` cycles after a detected falling edge. The first bit lands in bit 0 of the receive register (address 1). After 8 bits, status reads exactly 2 (bit 1, receive done) and go is cleared.
- R5: If no falling edge arrives within `TMO_CYC` cycles while a receive waits for a bit, status reads exactly 4 (bit 2, time-out), receive done stays clear, and go is cleared.
- R6: A read of the status register returns the flags and clears all of them.
- R7: The status register is cleared when a transfer starts, so flags left from an earlier transfer do not survive into the next one.
- R8: `irq` is high exactly when control bit 2 (interrupt enable) is set and any status flag is set, one cycle after the fact. With the enable clear, flags still set but `irq` stays 0.
- R9: A write of go = 1 while go is already set has no effect. No second transfer starts and the direction in flight does not change.
- R10: A single write to the control register that sets the direction bit (bit 0, 1 = receive) together with go starts a transfer in the direction just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on `reg_rdata` after the next edge |
| reg_addr | input | 2 | 0 transmit byte, 1 receive byte, 2 control, 3 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Combined interrupt |
| line_in | input | 1 | Sampled level of the bus wire |
| line_oe | output | 1 | High pulls the bus wire low |

## Verification
The assertions take for granted that register strobes are single-cycle pulses. They also assume the bus input is a real wire: it reads low whenever `line_oe` pulls it, so the receive engine sees no edges of its own making.

The bench keeps to these conditions. It models the bus as the inverse of the OR of the master's pull and a slave pull. It issues each register access as a one-cycle strobe. Slave pulses are placed so that every sample point lies well clear of an edge, even after the synchronizer delay.

// File: rtl/swire_pkg.sv
package swire_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TX      = 2'd1,
    ST_RX_WAIT = 2'd2,
    ST_RX_SAMP = 2'd3
  } eng_state_t;

  localparam logic [1:0] A_TXB  = 2'd0;
  localparam logic [1:0] A_RXB  = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam int C_DIR = 0;
  localparam int C_GO  = 1;
  localparam int C_IEN = 2;

  localparam int S_TXD = 0;
  localparam int S_RXD = 1;
  localparam int S_TMO = 2;
endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_s,
  output logic line_fell
);
  logic [STAGES-1:0] pipe;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe   <= '1;
      prev_q <= 1'b1;
    end else begin
      pipe   <= {pipe[STAGES-2:0], line_in};
      prev_q <= pipe[STAGES-1];
    end
  end

  assign line_s    = pipe[STAGES-1];
  assign line_fell = prev_q & ~pipe[STAGES-1];
endmodule

// File: rtl/swire_engine.sv
module swire_engine
  import swire_pkg::*;
#(
  parameter int DW         = 8,
  parameter int SLOT_CYC   = 40,
  parameter int LOW1_CYC   = 8,
  parameter int LOW0_CYC   = 28,
  parameter int SAMPLE_CYC = 18,
  parameter int TMO_CYC    = 200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          dir,
  input  logic [DW-1:0] tx_byte,
  input  logic          line_s,
  input  logic          line_fell,
  output logic          busy,
  output logic          drive_low,
  output logic          done_tx,
  output logic          done_rx,
  output logic          done_tmo,
  output logic [DW-1:0] rx_byte
);
  localparam int MAXC = (TMO_CYC > SLOT_CYC) ? TMO_CYC : SLOT_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int BW   = (DW > 1) ? $clog2(DW) : 1;

  eng_state_t    state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] shreg;
  logic [CW-1:0] lowlen;
  logic [CW-1:0] cnt_nx;

  assign lowlen = shreg[0] ? CW'(LOW1_CYC) : CW'(LOW0_CYC);
  assign cnt_nx = cnt + 1'b1;
  assign busy   = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      shreg     <= '0;
      drive_low <= 1'b0;
      done_tx   <= 1'b0;
      done_rx   <= 1'b0;
      done_tmo  <= 1'b0;
      rx_byte   <= '0;
    end else begin
      done_tx  <= 1'b0;
      done_rx  <= 1'b0;
      done_tmo <= 1'b0;
      case (state)
        ST_IDLE: begin
          drive_low <= 1'b0;
          if (start) begin
            cnt  <= '0;
            bitn <= '0;
            if (dir) begin
              state <= ST_RX_WAIT;
            end else begin
              state     <= ST_TX;
              shreg     <= tx_byte;
              drive_low <= 1'b1;
            end
          end
        end
        ST_TX: begin
          if (cnt == CW'(SLOT_CYC - 1)) begin
            cnt   <= '0;
            shreg <= {1'b0, shreg[DW-1:1]};
            if (bitn == BW'(DW - 1)) begin
              state     <= ST_IDLE;
              drive_low <= 1'b0;
              done_tx   <= 1'b1;
            end else begin
              bitn      <= bitn + 1'b1;
              drive_low <= 1'b1;
            end
          end else begin
            cnt       <= cnt_nx;
            drive_low <= (cnt_nx < lowlen);
          end
        end
        ST_RX_WAIT: begin
          if (line_fell) begin
            state <= ST_RX_SAMP;
            cnt   <= '0;
          end else if (cnt == CW'(TMO_CYC - 1)) begin
            state    <= ST_IDLE;
            done_tmo <= 1'b1;
          end else begin
            cnt <= cnt_nx;
          end
        end
        ST_RX_SAMP: begin
          if (cnt == CW'(SAMPLE_CYC - 1)) begin
            cnt   <= '0;
            shreg <= {line_s, shreg[DW-1:1]};
            if (bitn == BW'(DW - 1)) begin
              state   <= ST_IDLE;
              rx_byte <= {line_s, shreg[DW-1:1]};
              done_rx <= 1'b1;
            end else begin
              bitn  <= bitn + 1'b1;
              state <= ST_RX_WAIT;
            end
          end else begin
            cnt <= cnt_nx;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swire_regs.sv
module swire_regs
  import swire_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          done_tx,
  input  logic          done_rx,
  input  logic          done_tmo,
  input  logic [DW-1:0] rx_byte,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          start,
  output logic          dir,
  output logic          go,
  output logic          ien,
  output logic [DW-1:0] tx_byte,
  output logic [2:0]    status
);
  logic [DW-1:0] rx_q;
  logic [2:0]    status_n;

  always_comb begin
    status_n = status;
    if (rd && addr == A_STAT) status_n = '0;
    if (start)                status_n = '0;
    status_n[S_TXD] = status_n[S_TXD] | done_tx;
    status_n[S_RXD] = status_n[S_RXD] | done_rx;
    status_n[S_TMO] = status_n[S_TMO] | done_tmo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      irq     <= 1'b0;
      start   <= 1'b0;
      dir     <= 1'b0;
      go      <= 1'b0;
      ien     <= 1'b0;
      tx_byte <= '0;
      rx_q    <= '0;
      status  <= '0;
    end else begin
      start  <= 1'b0;
      status <= status_n;
      irq    <= ien & (|status);
      if (wr) begin
        case (addr)
          A_TXB: tx_byte <= wdata;
          A_CTRL: begin
            ien <= wdata[C_IEN];
            if (!go) begin
              dir <= wdata[C_DIR];
              if (wdata[C_GO]) begin
                go    <= 1'b1;
                start <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
      if (done_tx || done_rx || done_tmo) go <= 1'b0;
      if (done_rx) rx_q <= rx_byte;
      if (rd) begin
        case (addr)
          A_TXB:   rdata <= tx_byte;
          A_RXB:   rdata <= rx_q;
          A_CTRL:  rdata <= DW'({ien, go, dir});
          default: rdata <= DW'(status);
        endcase
      end
    end
  end
endmodule

// File: rtl/swire_master.sv
module swire_master #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_CYC    = 40,
  parameter int LOW1_CYC    = 8,
  parameter int LOW0_CYC    = 28,
  parameter int SAMPLE_CYC  = 18,
  parameter int TMO_CYC     = 200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  input  logic          line_in,
  output logic          line_oe
);
  logic          line_s, line_fell;
  logic          start, dir, go, ien, busy;
  logic          done_tx, done_rx, done_tmo;
  logic [DW-1:0] tx_byte, rx_byte;
  logic [2:0]    status;

  swire_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .line_in(line_in),
    .line_s(line_s), .line_fell(line_fell)
  );

  swire_regs #(.DW(DW)) regs_i (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .done_tx(done_tx), .done_rx(done_rx),
    .done_tmo(done_tmo), .rx_byte(rx_byte), .rdata(reg_rdata), .irq(irq),
    .start(start), .dir(dir), .go(go), .ien(ien), .tx_byte(tx_byte),
    .status(status)
  );

  swire_engine #(
    .DW(DW), .SLOT_CYC(SLOT_CYC), .LOW1_CYC(LOW1_CYC), .LOW0_CYC(LOW0_CYC),
    .SAMPLE_CYC(SAMPLE_CYC), .TMO_CYC(TMO_CYC)
  ) eng_i (
    .clk(clk), .rst(rst), .start(start), .dir(dir), .tx_byte(tx_byte),
    .line_s(line_s), .line_fell(line_fell), .busy(busy),
    .drive_low(line_oe), .done_tx(done_tx), .done_rx(done_rx),
    .done_tmo(done_tmo), .rx_byte(rx_byte)
  );
endmodule

// File: rtl/swire_master_chk.sv
module swire_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [1:0] reg_addr,
  input logic       irq,
  input logic       line_oe,
  input logic       busy,
  input logic       start,
  input logic       go,
  input logic       ien,
  input logic       done_tx,
  input logic       done_rx,
  input logic       done_tmo,
  input logic [2:0] status
);
  // R2
  oe_in_transfer_chk: assert property (@(posedge clk) disable iff (rst)
    line_oe |-> busy);
  // R3
  tx_done_flags_chk: assert property (@(posedge clk) disable iff (rst)
    done_tx |=> (status[0] && !status[2] && !go));
  // R5
  timeout_flags_chk: assert property (@(posedge clk) disable iff (rst)
    done_tmo |=> (status == 3'b100 && !go));
  // R5
  rx_tmo_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(status[1] && status[2]));
  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 2'd3 && !done_tx && !done_rx && !done_tmo)
      |=> (status == 3'b000));
  // R8
  masked_irq_chk: assert property (@(posedge clk) disable iff (rst)
    !ien |=> !irq);
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd2 && go) |=> !start);
endmodule

bind swire_master swire_master_chk chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .irq(irq), .line_oe(line_oe), .busy(busy),
  .start(start), .go(go), .ien(ien), .done_tx(done_tx),
  .done_rx(done_rx), .done_tmo(done_tmo), .status(status)
);

// File: tb/swire_master_tb.sv
module swire_master_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq, line_oe, line_in;
  logic       slave_low = 1'b0;
  int         n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;
  assign line_in = ~(line_oe | slave_low);

  swire_master dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .line_in(line_in), .line_oe(line_oe)
  );

  // Line monitor: decodes pulse widths into bits (short = 1, long = 0)
  logic       mon_clr = 1'b0;
  logic [7:0] mon_byte;
  int         mon_cnt, mon_run;
  always @(posedge clk) begin
    if (mon_clr) begin
      mon_byte <= 8'd0; mon_cnt <= 0; mon_run <= 0;
    end else if (line_oe) begin
      mon_run <= mon_run + 1;
    end else if (mon_run != 0) begin
      mon_byte <= {(mon_run < 18), mon_byte[7:1]};
      mon_cnt  <= mon_cnt + 1;
      mon_run  <= 0;
    end
  end

  // {dir, byte}; dir and go are always written together (R10)
  localparam logic [8:0] VEC [0:5] = '{9'h0A5, 9'h13C, 9'h000,
                                       9'h1FF, 9'h081, 9'h15A};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic clr_mon();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic slave_send(input logic [7:0] b);
    repeat (10) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      slave_low = 1'b1;
      repeat (b[i] ? 6 : 30) @(negedge clk);
      slave_low = 1'b0;
      repeat (20) @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    for (int k = 0; k < 3000; k++) begin
      rd_reg(2'd2, c);
      if (!c[1]) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R2 act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 line_oe", line_oe, 0);
    chk("R1 irq", irq, 0);
    rd_reg(2'd3, d); chk("R1 status", d, 0);
    rd_reg(2'd2, d); chk("R1 ctrl", d, 0);

    for (int v = 0; v < 6; v++) begin
      clr_mon();
      wr_reg(2'd0, VEC[v][7:0]);
      wr_reg(2'd2, {5'd0, 1'b1, 1'b1, VEC[v][8]});
      if (VEC[v][8]) slave_send(VEC[v][7:0]);
      wait_idle();
      repeat (2) @(negedge clk);
      chk("R8 irq set", irq, 1);
      rd_reg(2'd3, d);
      if (VEC[v][8]) begin
        chk("R4 rx status", d, 2);
        rd_reg(2'd1, d); chk("R4 rx byte", d, VEC[v][7:0]);
      end else begin
        chk("R3 tx status", d, 1);
        chk("R2 tx bits", mon_byte, VEC[v][7:0]);
        chk("R2 tx slots", mon_cnt, 8);
      end
      rd_reg(2'd2, d); chk("R3 go cleared", d[1], 0);
      rd_reg(2'd3, d); chk("R6 read clears", d, 0);
      chk("R8 irq clear", irq, 0);
    end

    // R5 time-out: receive with silent slave
    wr_reg(2'd2, 8'h07);
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R5 irq", irq, 1);
    rd_reg(2'd2, d); chk("R5 go cleared", d[1], 0);
    // leave time-out flag set (not read) for R7
    // R7 and R8: transmit with interrupt masked
    clr_mon();
    wr_reg(2'd0, 8'h96);
    wr_reg(2'd2, 8'h02);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R8 masked irq", irq, 0);
    rd_reg(2'd3, d); chk("R7 start clears stale flag", d, 1);
    chk("R2 masked tx bits", mon_byte, 8'h96);

    // R5 flag check on its own
    wr_reg(2'd2, 8'h01 | 8'h02);
    wait_idle();
    rd_reg(2'd3, d); chk("R5 status timeout only", d, 4);

    // R9: go rewritten during a transmit
    clr_mon();
    wr_reg(2'd0, 8'hC3);
    wr_reg(2'd2, 8'h06);
    repeat (50) @(negedge clk);
    wr_reg(2'd2, 8'h07);
    wait_idle();
    rd_reg(2'd3, d); chk("R9 status tx only", d, 1);
    chk("R9 byte intact", mon_byte, 8'hC3);
    repeat (300) @(negedge clk);
    chk("R9 no extra transfer", mon_cnt, 8);
    rd_reg(2'd2, d); chk("R9 go idle", d[1], 0);
    chk("R2 line released", line_oe, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule